// File: doc/BRIEF.md
# Character display bus sequencer

This block sits between a host-side command stream and a parallel character display module. The host offers one request at a time over a valid/ready handshake. Each request is a register-select bit, a direction bit and a byte. The sequencer runs the display's bus cycle for that request. It drives the select, direction and data lines, opens the strobe window, and releases the bus cleanly afterwards.

After each bus cycle the sequencer holds off the next request until the display can accept more work. In timed mode it decodes the request into an execution class and waits a fixed number of clock cycles for that class. Clear-screen and cursor-home instructions form the long class. Other instructions and all RAM data transfers form the short class. Status reads have no wait. In polling mode it skips the fixed wait and repeats status reads until the display reports ready. If the display stays busy too long, the sequencer gives up and raises an error flag.

Reads capture the display's data bus in the last strobe cycle and return the byte alongside the completion pulse.

Top module: `disp_cmd_seq`

## Requirements
- R1: During and right after reset the sequencer is idle: `req_ready_o`=1, while `lcd_en_o`, `lcd_db_oe_o`, `done_o`, `rsp_valid_o` and `err_o` are 0.
- R2: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` stays 0 from the cycle after acceptance until `done_o` has been high.
- R3: `lcd_rs_o` and `lcd_rw_o` settle at least one cycle before `lcd_en_o` rises and keep their values in the first cycle after it falls. Every strobe is exactly `EN_CYC` cycles high.
- R4: The bus cycle of a request puts its select bit on `lcd_rs_o` and its direction bit on `lcd_rw_o` (1 = read). For a write, the byte is on `lcd_db_o` with `lcd_db_oe_o`=1. While `lcd_rw_o`=1, `lcd_db_oe_o` is 0.
- R5: In timed mode, an instruction write (select 0, write) with byte 01h, 02h or 03h is followed by a wait of `LONG_CYC` cycles. Acceptance to `done_o` then takes 2+`EN_CYC`+`LONG_CYC` edges.
- R6: In timed mode, every other instruction write, and every RAM data write or read (select 1), waits `SHORT_CYC` cycles. Acceptance to `done_o` then takes 2+`EN_CYC`+`SHORT_CYC` edges.
- R7: A status read (select 0, read) has no wait in timed mode. `done_o` comes 2+`EN_CYC` edges after acceptance.
- R8: For a read request, the byte on `lcd_db_i` during the last strobe cycle appears on `rsp_data_o`. `rsp_valid_o` is high only in the `done_o` cycle of a read.
- R9: In polling mode, each bus cycle of the request is followed by status reads (select 0, read), each taking 2+`EN_CYC` cycles. The reads stop at the first one with bit 7 clear, and `done_o` follows in the next cycle.
- R10: If `POLL_MAX` status reads in a row all show bit 7 set, `err_o` goes to 1 together with `done_o`. It stays 1 until the next request is accepted.
- R11: `done_o` is a single-cycle pulse, and `req_ready_o` is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_mode_i | input | 1 | Sampled at acceptance: 1 = poll busy bit, 0 = timed wait |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_rs_i | input | 1 | Register select of request (0 instruction/status, 1 RAM data) |
| req_rw_i | input | 1 | Direction of request (1 read) |
| req_data_i | input | 8 | Byte to write |
| done_o | output | 1 | Request finished, wait or poll over |
| rsp_valid_o | output | 1 | Read byte valid |
| rsp_data_o | output | 8 | Read byte |
| err_o | output | 1 | Busy poll timed out |
| lcd_rs_o | output | 1 | Display register select |
| lcd_rw_o | output | 1 | Display direction |
| lcd_en_o | output | 1 | Display strobe |
| lcd_db_o | output | 8 | Display data bus, outgoing |
| lcd_db_oe_o | output | 1 | Drive enable for the data bus |
| lcd_db_i | input | 8 | Display data bus, incoming |

## Verification
An error in the wait class or the wait counter shows up as a `done_o` that comes too early or too late by a whole class length. The bench measures the acceptance-to-done edge count of every request, so such an error appears on the first request of the affected class. A wrong poll state shows at the ports as an extra or missing status strobe, or as a wrong `err_o`, which the bench catches when that request completes. A control-line timing fault shows within the strobe itself: the wrong width, or select and direction moving at a strobe edge.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

  localparam int unsigned BUSY_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_WAIT,
    ST_DONE
  } seq_st_e;

  typedef enum logic [1:0] {
    CLS_NONE,
    CLS_SHORT,
    CLS_LONG
  } wait_cls_e;

  typedef struct packed {
    logic       rs;
    logic       rw;
    logic [7:0] data;
  } disp_req_t;

endpackage

// File: rtl/disp_cmd_class.sv
module disp_cmd_class
  import disp_seq_pkg::*;
(
  input  logic       rs_i,
  input  logic       rw_i,
  input  logic [7:0] byte_i,
  output wait_cls_e  cls_o
);

  always_comb begin
    if (rw_i) begin
      cls_o = rs_i ? CLS_SHORT : CLS_NONE;   // status read has no execution time
    end else if (rs_i) begin
      cls_o = CLS_SHORT;
    end else if (byte_i == 8'h01 || byte_i[7:1] == 7'h01) begin
      cls_o = CLS_LONG;                      // clear, home
    end else begin
      cls_o = CLS_SHORT;
    end
  end

endmodule

// File: rtl/disp_down_ctr.sv
module disp_down_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/disp_cmd_seq.sv
module disp_cmd_seq
  import disp_seq_pkg::*;
#(
  parameter int unsigned EN_CYC    = 12,
  parameter int unsigned SHORT_CYC = 1850,
  parameter int unsigned LONG_CYC  = 76000,
  parameter int unsigned POLL_MAX  = 255
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       poll_mode_i,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic       req_rs_i,
  input  logic       req_rw_i,
  input  logic [7:0] req_data_i,
  output logic       done_o,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o,
  output logic       err_o,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o,
  output logic       lcd_en_o,
  output logic [7:0] lcd_db_o,
  output logic       lcd_db_oe_o,
  input  logic [7:0] lcd_db_i
);

  localparam int unsigned CNT_W  = $clog2(LONG_CYC + SHORT_CYC + EN_CYC + 1);
  localparam int unsigned POLL_W = $clog2(POLL_MAX + 1);

  seq_st_e           state_q, st_d;
  disp_req_t         req_q;
  wait_cls_e         cls;
  logic              poll_q, polling_q, stat_busy_q, err_q, bus_rs_q, bus_rw_q;
  logic [POLL_W-1:0] poll_cnt_q;
  logic [7:0]        rsp_q;
  logic              ctr_load, ctr_zero, accept, poll_start, poll_again, timeout, capture;
  logic [CNT_W-1:0]  ctr_val;

  disp_cmd_class u_class (
    .rs_i   (req_q.rs),
    .rw_i   (req_q.rw),
    .byte_i (req_q.data),
    .cls_o  (cls)
  );

  disp_down_ctr #(.W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctr_load),
    .val_i  (ctr_val),
    .zero_o (ctr_zero)
  );

  assign capture = (state_q == ST_PULSE) && ctr_zero;

  always_comb begin
    st_d       = state_q;
    ctr_load   = 1'b0;
    ctr_val    = '0;
    accept     = 1'b0;
    poll_start = 1'b0;
    poll_again = 1'b0;
    timeout    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          accept = 1'b1;
          st_d   = ST_SETUP;
        end
      end
      ST_SETUP: begin
        ctr_load = 1'b1;
        ctr_val  = CNT_W'(EN_CYC - 1);
        st_d     = ST_PULSE;
      end
      ST_PULSE: begin
        if (ctr_zero) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (polling_q) begin
          if (!stat_busy_q) begin
            st_d = ST_DONE;
          end else if (poll_cnt_q == POLL_W'(POLL_MAX)) begin
            timeout = 1'b1;
            st_d    = ST_DONE;
          end else begin
            poll_again = 1'b1;
            st_d       = ST_SETUP;
          end
        end else if (poll_q) begin
          poll_start = 1'b1;
          st_d       = ST_SETUP;
        end else begin
          unique case (cls)
            CLS_LONG: begin
              ctr_load = 1'b1;
              ctr_val  = CNT_W'(LONG_CYC - 1);
              st_d     = ST_WAIT;
            end
            CLS_SHORT: begin
              ctr_load = 1'b1;
              ctr_val  = CNT_W'(SHORT_CYC - 1);
              st_d     = ST_WAIT;
            end
            default: st_d = ST_DONE;
          endcase
        end
      end
      ST_WAIT: begin
        if (ctr_zero) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      req_q       <= '0;
      poll_q      <= 1'b0;
      polling_q   <= 1'b0;
      poll_cnt_q  <= '0;
      stat_busy_q <= 1'b0;
      rsp_q       <= '0;
      err_q       <= 1'b0;
      bus_rs_q    <= 1'b0;
      bus_rw_q    <= 1'b0;
    end else begin
      state_q <= st_d;
      if (accept) begin
        req_q      <= '{rs: req_rs_i, rw: req_rw_i, data: req_data_i};
        poll_q     <= poll_mode_i;
        polling_q  <= 1'b0;
        poll_cnt_q <= '0;
        err_q      <= 1'b0;
        bus_rs_q   <= req_rs_i;
        bus_rw_q   <= req_rw_i;
      end
      if (poll_start || poll_again) begin
        bus_rs_q  <= 1'b0;
        bus_rw_q  <= 1'b1;
        polling_q <= 1'b1;
      end
      if (capture) begin
        if (polling_q) begin
          stat_busy_q <= lcd_db_i[BUSY_BIT];
          poll_cnt_q  <= poll_cnt_q + 1'b1;
        end else if (req_q.rw) begin
          rsp_q <= lcd_db_i;
        end
      end
      if (timeout) err_q <= 1'b1;
      if (state_q == ST_DONE) polling_q <= 1'b0;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign rsp_valid_o = done_o && req_q.rw;
  assign rsp_data_o  = rsp_q;
  assign err_o       = err_q;
  assign lcd_rs_o    = bus_rs_q;
  assign lcd_rw_o    = bus_rw_q;
  assign lcd_en_o    = (state_q == ST_PULSE);
  assign lcd_db_o    = req_q.data;
  assign lcd_db_oe_o = !bus_rw_q &&
                       (state_q == ST_SETUP || state_q == ST_PULSE || state_q == ST_HOLD);

endmodule

// File: rtl/disp_cmd_seq_chk.sv
module disp_cmd_seq_chk #(
  parameter int unsigned EN_CYC = 12
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic done_o,
  input logic rsp_valid_o,
  input logic err_o,
  input logic lcd_rs_o,
  input logic lcd_rw_o,
  input logic lcd_en_o,
  input logic lcd_db_oe_o
);

  logic [31:0] en_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_run_q <= '0;
    else if (lcd_en_o) en_run_q <= en_run_q + 1'b1;
    else               en_run_q <= '0;
  end

  AST_CTRL_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_en_o) |-> $stable(lcd_rs_o) && $stable(lcd_rw_o)); // R3
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_en_o) |-> $stable(lcd_rs_o) && $stable(lcd_rw_o)); // R3
  AST_EN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_en_o) |-> en_run_q == EN_CYC); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_rw_o |-> !lcd_db_oe_o); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_en_o |-> !req_ready_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o); // R11
  AST_RSP_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> done_o); // R8
  AST_ERR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o); // R10

endmodule

bind disp_cmd_seq disp_cmd_seq_chk #(.EN_CYC(EN_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .rsp_valid_o (rsp_valid_o),
  .err_o       (err_o),
  .lcd_rs_o    (lcd_rs_o),
  .lcd_rw_o    (lcd_rw_o),
  .lcd_en_o    (lcd_en_o),
  .lcd_db_oe_o (lcd_db_oe_o)
);

// File: tb/tb_disp_cmd_seq.sv
`timescale 1ns/1ps
module tb_disp_cmd_seq;

  localparam int EN   = 3;
  localparam int SHRT = 7;
  localparam int LNG  = 25;
  localparam int PMAX = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll_mode = 1'b0, req_valid = 1'b0, req_rs = 1'b0, req_rw = 1'b0;
  logic [7:0] req_data = '0;
  logic req_ready, done, rsp_valid, err, lcd_rs, lcd_rw, lcd_en, lcd_db_oe;
  logic [7:0] rsp_data, lcd_db_o, lcd_db_i;

  int checks = 0, errors = 0;
  int busy_left = 0, xfer_n = 0, en_run = 0;
  logic [7:0] rd_byte = 8'h00;
  logic f_rs, f_rw, f_oe;
  logic [7:0] f_db;

  always #10 clk = ~clk;

  disp_cmd_seq #(.EN_CYC(EN), .SHORT_CYC(SHRT), .LONG_CYC(LNG), .POLL_MAX(PMAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .poll_mode_i(poll_mode),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_rs_i(req_rs), .req_rw_i(req_rw), .req_data_i(req_data),
    .done_o(done), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .err_o(err),
    .lcd_rs_o(lcd_rs), .lcd_rw_o(lcd_rw), .lcd_en_o(lcd_en),
    .lcd_db_o(lcd_db_o), .lcd_db_oe_o(lcd_db_oe), .lcd_db_i(lcd_db_i)
  );

  // display model: status byte = {busy, address 2Ah}
  assign lcd_db_i = lcd_rs ? rd_byte : {busy_left != 0, 7'h2A};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // strobe monitor, sampled at negedge
  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_en) en_run++;
      else if (en_run != 0) begin
        chk(en_run == EN, "R3 strobe width", en_run, EN);
        if (xfer_n == 0) begin
          f_rs = lcd_rs; f_rw = lcd_rw; f_db = lcd_db_o; f_oe = lcd_db_oe;
        end
        if (!lcd_rs && lcd_rw && busy_left > 0) busy_left--;
        xfer_n++;
        en_run = 0;
      end
    end
  end

  function automatic int wait_of(bit rs, bit rw, logic [7:0] d);
    if (rw) return rs ? SHRT : 0;
    if (!rs && (d == 8'h01 || d == 8'h02 || d == 8'h03)) return LNG;
    return SHRT;
  endfunction

  function automatic int polls_of(int busy_n);
    return (busy_n >= PMAX) ? PMAX : busy_n + 1;
  endfunction

  task automatic do_req(input bit rs, input bit rw, input logic [7:0] d,
                        input bit poll, input int busy_n);
    int e, exp_e, polls;
    bit exp_err;
    string tag;
    logic [7:0] exp_rsp;
    polls   = poll ? polls_of(busy_n) : 0;
    exp_err = poll && busy_n >= PMAX;
    exp_e   = poll ? (2 + EN) * (1 + polls) : 2 + EN + wait_of(rs, rw, d);
    if (poll)                       tag = "R9 poll timing";
    else if (wait_of(rs, rw, d) == LNG) tag = "R5 long wait";
    else if (rw && !rs)             tag = "R7 status no wait";
    else                            tag = "R6 short wait";
    @(negedge clk);
    busy_left = busy_n; xfer_n = 0; rd_byte = 8'($urandom);
    exp_rsp = rs ? rd_byte : {busy_n != 0, 7'h2A};
    req_rs = rs; req_rw = rw; req_data = d; poll_mode = poll; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
    @(posedge clk);
    e = 0;
    forever begin
      @(negedge clk);
      if (e == 0) begin
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
        chk(err == 1'b0, "R10 err cleared at accept", err, 0);
      end
      if (done) break;
      @(posedge clk);
      e++;
    end
    chk(e == exp_e, tag, e, exp_e);
    chk(xfer_n == 1 + polls, "R9 strobe count", xfer_n, 1 + polls);
    chk(err == exp_err, "R10 timeout flag", err, exp_err);
    chk(rsp_valid == rw, "R8 rsp_valid", rsp_valid, rw);
    if (rw) chk(rsp_data == exp_rsp, "R8 read byte", rsp_data, exp_rsp);
    chk(f_rs == rs && f_rw == rw, "R4 select/direction", {f_rs, f_rw}, {rs, rw});
    if (!rw) chk(f_db == d && f_oe, "R4 write byte", {f_oe, f_db}, {1'b1, d});
    @(negedge clk);
    chk(!done && req_ready, "R11 done pulse", {done, req_ready}, 1);
    if (exp_err) chk(err == 1'b1, "R10 err sticky", err, 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(req_ready && !lcd_en && !lcd_db_oe && !done && !rsp_valid && !err,
        "R1 reset state", {req_ready, lcd_en, lcd_db_oe, done, rsp_valid, err}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !lcd_en && !done, "R1 after reset", {req_ready, lcd_en, done}, 3'b100);
    // directed corners
    do_req(1'b0, 1'b0, 8'h01, 1'b0, 0);  // R5 clear
    do_req(1'b0, 1'b0, 8'h02, 1'b0, 0);  // R5 home
    do_req(1'b0, 1'b0, 8'h03, 1'b0, 0);  // R5 home, low bit don't care
    do_req(1'b0, 1'b0, 8'h04, 1'b0, 0);  // R6 next code up
    do_req(1'b0, 1'b0, 8'h00, 1'b0, 0);  // R6
    do_req(1'b1, 1'b0, 8'h01, 1'b0, 0);  // R6 data byte 01h is not clear
    do_req(1'b0, 1'b1, 8'h00, 1'b0, 1);  // R7 status read, busy seen
    do_req(1'b0, 1'b1, 8'h00, 1'b0, 0);  // R7
    do_req(1'b1, 1'b1, 8'h00, 1'b0, 0);  // R8 data read
    do_req(1'b0, 1'b0, 8'h38, 1'b1, 0);  // R9 ready at once
    do_req(1'b0, 1'b0, 8'h01, 1'b1, PMAX - 1); // R9 last allowed poll
    do_req(1'b1, 1'b0, 8'h41, 1'b1, PMAX);     // R10 timeout
    do_req(1'b0, 1'b0, 8'h0C, 1'b0, 0);  // R10 err cleared
    // constrained random
    for (int i = 0; i < 40; i++) begin
      int k;
      logic [7:0] d;
      k = $urandom % 6;
      d = 8'($urandom);
      case (k)
        0: do_req(1'b0, 1'b0, 8'($urandom % 4), 1'b0, 0);
        1: do_req(1'b0, 1'b0, d, 1'b0, 0);
        2: do_req(1'b1, 1'b0, d, 1'b0, 0);
        3: do_req(1'b1, 1'b1, 8'h00, 1'b0, 0);
        4: do_req(1'b0, 1'b1, 8'h00, 1'b0, $urandom % 2);
        default: do_req(1'($urandom), 1'b0, d, 1'b1, $urandom % (PMAX + 2));
      endcase
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule